// File: doc/BRIEF.md
# Byte/Word ALU with Status and Control Flags

This block is a two-operand arithmetic and logic unit that works on either 8-bit or 16-bit operands. It handles add, add with carry, subtract, subtract with borrow, AND, OR and XOR. For every accepted operation it registers the result and six status bits: overflow, sign, zero, auxiliary carry, parity and carry. It also holds three control bits (trap, direction and interrupt enable) that only a separate load port can change.

The nine bits leave the block as one packed flag word with a fixed layout. A neighbouring sequencer can then save and restore it as a single value. The carry-in operations (add with carry, subtract with borrow) take their extra input from the carry bit currently held in the flag word. This lets software chain byte or word operations into wider arithmetic.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, `result` and all nine bits of `flags` are 0.
- R2: When `op_valid` is 1, `op_code` selects the operation: 0 add, 1 add with carry, 2 subtract (A−B), 3 subtract with borrow (A−B−CF), 4 AND, 5 OR, 6 XOR. The result is on `result` from the first rising edge after the operation is accepted.
- R3: `flags[0]` (CF) is the carry out of the top operand bit for the add operations, and the borrow for the subtract operations. Add with carry and subtract with borrow use the CF value held before the edge.
- R4: `flags[5]` (OF) is 1 on signed overflow. For an add this means both operands have the same sign and the result sign differs. For a subtract it means the operand signs differ and the result sign differs from A.
- R5: `flags[4]` (SF) equals the top bit of the result (bit 7 in byte mode, bit 15 in word mode). `flags[3]` (ZF) is 1 exactly when the result of the selected width is zero.
- R6: `flags[2]` (AF) is the carry or borrow out of bit 3 for the arithmetic operations, in both widths.
- R7: `flags[1]` (PF) is 1 when the low 8 bits of the result hold an even number of ones.
- R8: The AND, OR and XOR operations leave OF, CF and AF at 0 and set SF, ZF and PF from the result.
- R9: With `word_mode` at 0, the upper operand bytes are ignored and `result[15:8]` is 0.
- R10: A cycle with `ctl_load` high writes `ctl_in[2:0]` into `flags[8:6]` (trap, direction, interrupt). Without `ctl_load` those bits hold, and operations never change them.
- R11: When `op_valid` is 0, or when `op_code` is 7, `result` and `flags[5:0]` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_code | input | 3 | Operation select |
| word_mode | input | 1 | 1: 16-bit operation, 0: 8-bit operation |
| opnd_a | input | 16 | First operand (minuend) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| ctl_load | input | 1 | Write the control bits |
| ctl_in | input | 3 | New trap, direction, interrupt bits (MSB first) |
| result | output | 16 | Registered result |
| flags | output | 9 | {TF, DF, IF, OF, SF, ZF, AF, PF, CF} |

## Verification
Each output is due one rising edge after the cycle that presents its stimulus: the result and status bits after an accepted operation, and the control bits after a load. The bench applies inputs on the falling edge and updates its model at the rising edge. It compares every field at the following falling edge, before it drives the next stimulus. Held values (an idle cycle, code 7, control bits during operations) are compared in the same cycle, against the model that was not advanced.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_NOP = 3'd7
  } alu_op_e;

  localparam int FLAG_W = 9;
  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;
  localparam int STAT_W = 6;
  localparam int CTL_W = 3;
endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              sub_sel,
  input  logic              cin,
  input  logic              wide,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out,
  output logic              aux_out,
  output logic              ovf_out
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] ext_sum;
  logic [4:0]      nib_sum;
  logic            sa, sb, sr;

  always_comb begin
    if (sub_sel) begin
      ext_sum = {1'b0, a_in} - {1'b0, b_in} - {{DATA_W{1'b0}}, cin};
      nib_sum = {1'b0, a_in[3:0]} - {1'b0, b_in[3:0]} - {4'd0, cin};
    end else begin
      ext_sum = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin};
      nib_sum = {1'b0, a_in[3:0]} + {1'b0, b_in[3:0]} + {4'd0, cin};
    end
    sum_out   = wide ? ext_sum[DATA_W-1:0] : {{HALF_W{1'b0}}, ext_sum[HALF_W-1:0]};
    carry_out = wide ? ext_sum[DATA_W] : ext_sum[HALF_W];
    aux_out   = nib_sum[4];
    sa        = wide ? a_in[DATA_W-1] : a_in[HALF_W-1];
    sb        = wide ? b_in[DATA_W-1] : b_in[HALF_W-1];
    sr        = wide ? ext_sum[DATA_W-1] : ext_sum[HALF_W-1];
    ovf_out   = sub_sel ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end
endmodule

// File: rtl/flag_alu_status.sv
module flag_alu_status #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_in,
  input  logic              wide,
  output logic              sign_out,
  output logic              zero_out,
  output logic              par_out
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] par_chain;

  assign par_chain[0] = res_in[0];
  genvar gi;
  generate
    for (gi = 1; gi < HALF_W; gi++) begin : g_par
      assign par_chain[gi] = par_chain[gi-1] ^ res_in[gi];
    end
  endgenerate

  always_comb begin
    par_out  = ~par_chain[HALF_W-1];
    sign_out = wide ? res_in[DATA_W-1] : res_in[HALF_W-1];
    zero_out = wide ? (res_in == '0) : (res_in[HALF_W-1:0] == '0);
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              ctl_load,
  input  logic [CTL_W-1:0]  ctl_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op_e;
  logic [DATA_W-1:0] a_m, b_m;
  logic [DATA_W-1:0] arith_sum, logic_res, res_d, res_q;
  logic              arith_c, arith_af, arith_of;
  logic              st_sf, st_zf, st_pf;
  logic              is_sub, use_cin, is_logic, op_en, ctl_en;
  logic [STAT_W-1:0] stat_d, stat_q;
  logic [CTL_W-1:0]  ctl_d, ctl_q;

  assign op_e = alu_op_e'(op_code);
  assign a_m  = word_mode ? opnd_a : {{HALF_W{1'b0}}, opnd_a[HALF_W-1:0]};
  assign b_m  = word_mode ? opnd_b : {{HALF_W{1'b0}}, opnd_b[HALF_W-1:0]};

  assign is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB);
  assign use_cin  = (op_e == OP_ADC) || (op_e == OP_SBB);
  assign is_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
  assign op_en    = op_valid && (op_e != OP_NOP);
  assign ctl_en   = ctl_load;

  flag_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_in      (a_m),
    .b_in      (b_m),
    .sub_sel   (is_sub),
    .cin       (use_cin & stat_q[F_CF]),
    .wide      (word_mode),
    .sum_out   (arith_sum),
    .carry_out (arith_c),
    .aux_out   (arith_af),
    .ovf_out   (arith_of)
  );

  always_comb begin
    unique case (op_e)
      OP_AND:  logic_res = a_m & b_m;
      OP_OR:   logic_res = a_m | b_m;
      default: logic_res = a_m ^ b_m;
    endcase
    res_d = is_logic ? logic_res : arith_sum;
  end

  flag_alu_status #(.DATA_W(DATA_W)) u_status (
    .res_in   (res_d),
    .wide     (word_mode),
    .sign_out (st_sf),
    .zero_out (st_zf),
    .par_out  (st_pf)
  );

  always_comb begin
    stat_d       = '0;
    stat_d[F_SF] = st_sf;
    stat_d[F_ZF] = st_zf;
    stat_d[F_PF] = st_pf;
    stat_d[F_OF] = is_logic ? 1'b0 : arith_of;
    stat_d[F_CF] = is_logic ? 1'b0 : arith_c;
    stat_d[F_AF] = is_logic ? 1'b0 : arith_af;
    ctl_d        = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      stat_q <= '0;
    end else if (op_en) begin
      res_q  <= res_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign result = res_q;
  assign flags  = {ctl_q, stat_q};

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (result == '0 && flags == '0)); // R1
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> flags[FLAG_W-1 -: CTL_W] == $past(ctl_in)); // R10
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_load |=> $stable(flags[FLAG_W-1 -: CTL_W])); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code == 3'd7) |=> ($stable(result) && $stable(flags[STAT_W-1:0]))); // R11
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code inside {3'd4, 3'd5, 3'd6}) |=>
      (flags[F_OF] == 1'b0 && flags[F_CF] == 1'b0 && flags[F_AF] == 1'b0)); // R8
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 3'd7 && !word_mode) |=> result[DATA_W-1:HALF_W] == '0); // R9
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 3'd7 && word_mode) |=> flags[F_ZF] == (result == '0)); // R5
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 3'd7 && word_mode) |=> flags[F_SF] == result[DATA_W-1]); // R5
endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic        word_mode;
  logic [15:0] opnd_a, opnd_b;
  logic        ctl_load;
  logic [2:0]  ctl_in;
  logic [15:0] result;
  logic [8:0]  flags;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_res;
  logic [8:0]  m_flg;
  bit          done = 0;

  flag_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ctl_load(ctl_load), .ctl_in(ctl_in), .result(result), .flags(flags)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: returns {status[5:0], result[15:0]}
  function automatic logic [21:0] ref_op(input logic [2:0] code, input logic w,
                                         input logic [15:0] a, input logic [15:0] b,
                                         input logic cf_in);
    int n, top, av, bv, ci, full, r, mask;
    logic sa, sb, sr, of, cf, af, zf, sf, pf;
    n = w ? 16 : 8;
    mask = (1 << n) - 1;
    av = int'(a) & mask;
    bv = int'(b) & mask;
    ci = (code == 3'd1 || code == 3'd3) ? int'(cf_in) : 0;
    of = 0; cf = 0; af = 0;
    case (code)
      3'd0, 3'd1: begin
        full = av + bv + ci;
        cf = (full > mask);
        af = (((av & 15) + (bv & 15) + ci) > 15);
      end
      3'd2, 3'd3: begin
        full = av - bv - ci;
        cf = (full < 0);
        af = (((av & 15) - (bv & 15) - ci) < 0);
      end
      3'd4: full = av & bv;
      3'd5: full = av | bv;
      default: full = av ^ bv;
    endcase
    r = full & mask;
    top = n - 1;
    sa = av[top]; sb = bv[top]; sr = r[top];
    if (code <= 3'd1) of = (sa == sb) && (sr != sa);
    else if (code <= 3'd3) of = (sa != sb) && (sr != sa);
    sf = sr;
    zf = (r == 0);
    pf = ~^r[7:0];
    return {of, sf, zf, af, pf, cf, r[15:0]};
  endfunction

  task automatic compare_all(input string ctx);
    chk({ctx, " R2 result"}, result, m_res);
    chk({ctx, " R3 CF"}, {15'd0, flags[0]}, {15'd0, m_flg[0]});
    chk({ctx, " R4 OF"}, {15'd0, flags[5]}, {15'd0, m_flg[5]});
    chk({ctx, " R5 SF/ZF"}, {14'd0, flags[4:3]}, {14'd0, m_flg[4:3]});
    chk({ctx, " R6 AF"}, {15'd0, flags[2]}, {15'd0, m_flg[2]});
    chk({ctx, " R7 PF"}, {15'd0, flags[1]}, {15'd0, m_flg[1]});
    chk({ctx, " R10 ctl"}, {13'd0, flags[8:6]}, {13'd0, m_flg[8:6]});
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic do_op(input logic v, input logic [2:0] c, input logic w,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic cl, input logic [2:0] ci, input string ctx);
    logic [21:0] r;
    op_valid = v; op_code = c; word_mode = w; opnd_a = a; opnd_b = b;
    ctl_load = cl; ctl_in = ci;
    @(posedge clk);
    r = ref_op(c, w, a, b, m_flg[0]);
    if (v && c != 3'd7) begin
      m_res = r[15:0];
      m_flg[5:0] = r[21:16];
    end
    if (cl) m_flg[8:6] = ci;
    @(negedge clk);
    compare_all(ctx);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 0; op_valid = 0; op_code = 0; word_mode = 0;
    opnd_a = 0; opnd_b = 0; ctl_load = 0; ctl_in = 0;
    m_res = 0; m_flg = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset result", result, 16'd0);
    chk("R1 reset flags", {7'd0, flags}, 16'd0);
    rst_n = 1;
    @(negedge clk);

    // Directed: byte add B5+96 -> 4B, OF=1 SF=0 ZF=0 AF=0 PF=1 CF=1
    do_op(1, 3'd0, 0, 16'h00B5, 16'h0096, 0, 3'd0, "dir_add_b5_96");
    chk("R3 R4 R5 R6 R7 directed flags", {7'd0, flags}, 16'h0023);
    // ADC uses CF=1
    do_op(1, 3'd1, 0, 16'h0001, 16'h0001, 0, 3'd0, "R3 adc");
    chk("R3 adc value", result, 16'h0003);
    // word sub borrow and zero
    do_op(1, 3'd2, 1, 16'h0000, 16'h0001, 0, 3'd0, "R3 sub borrow");
    chk("R3 word borrow result", result, 16'hFFFF);
    do_op(1, 3'd3, 1, 16'h0005, 16'h0004, 0, 3'd0, "R3 sbb");
    chk("R5 sbb zero", {15'd0, flags[3]}, 16'd1);
    // word overflow 7FFF+1
    do_op(1, 3'd0, 1, 16'h7FFF, 16'h0001, 0, 3'd0, "R4 word ovf");
    chk("R4 word ovf bit", {15'd0, flags[5]}, 16'd1);
    // sub overflow 8000-1
    do_op(1, 3'd2, 1, 16'h8000, 16'h0001, 0, 3'd0, "R4 sub ovf");
    // AF from nibble carry in word mode
    do_op(1, 3'd0, 1, 16'h000F, 16'h0001, 0, 3'd0, "R6 word af");
    chk("R6 af set", {15'd0, flags[2]}, 16'd1);
    // logic op after flags set: clears OF CF AF
    do_op(1, 3'd0, 0, 16'h00FF, 16'h00FF, 0, 3'd0, "R8 prep");
    do_op(1, 3'd4, 0, 16'h00F0, 16'h00FF, 0, 3'd0, "R8 and");
    chk("R8 cleared", {13'd0, flags[5], flags[2], flags[0]}, 16'd0);
    // byte mode ignores upper operand bytes
    do_op(1, 3'd6, 0, 16'hAB12, 16'hCD34, 0, 3'd0, "R9 byte xor");
    chk("R9 upper zero", {8'd0, result[15:8]}, 16'd0);
    // control load, then ops keep it
    do_op(0, 3'd0, 0, 16'h0, 16'h0, 1, 3'b101, "R10 load");
    chk("R10 ctl loaded", {13'd0, flags[8:6]}, 16'h0005);
    do_op(1, 3'd5, 1, 16'h1234, 16'h4321, 0, 3'b010, "R10 hold during op");
    // idle and code 7 hold
    do_op(0, 3'd0, 1, 16'hFFFF, 16'hFFFF, 0, 3'd0, "R11 idle");
    do_op(1, 3'd7, 1, 16'hFFFF, 16'h0001, 0, 3'd0, "R11 code7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      do_op(($urandom_range(0, 9) != 0), c, 1'($urandom),
            16'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0),
            3'($urandom), "R2 random");
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule